// File: doc/BRIEF.md
# E1 Spare-Bit Change and Persistence Monitor

This block watches the four national spare bits (Sa5, Sa6, Sa7 and Sa8) carried in the non-frame-alignment frames of a received E1 stream. It runs two kinds of check. The first is per frame: it flags any spare bit whose value differs from the frame before, and it has a separate flag for Sa5. The second is per CRC-4 sub-multiframe: four consecutive frames are gathered into one nibble for each spare bit, and a nibble that differs from the one in the previous sub-multiframe sets a flag. Sa6 has its own nibble-change flag.

The block also tracks how long the Sa6 nibble has stayed the same. When eight sub-multiframes in a row carry an identical Sa6 nibble, a persistence flag sets. At that moment the current Sa5 bit and the Sa6 nibble are captured into the status word, so software can read the pattern that persisted. The whole status word clears when software reads it, or when it reads a companion interrupt register. Frame alignment and bit extraction happen upstream. The block receives the spare bits with a frame strobe, and a second strobe marks the last frame of each sub-multiframe.

Top module: `sa_change_monitor`

## Requirements
- R1: The status word is 16 bits wide, and bit 15 and bits 4..0 always read 0. While the block is in reset, and directly after reset, the whole word is 0.
- R2: Bit 6 sets on a frame strobe when saBits[3] (Sa5) differs from the value it had on the previous frame strobe.
- R3: Bit 5 sets on a frame strobe when any of saBits[3:0] (Sa5, Sa6, Sa7, Sa8) differs from its value on the previous frame strobe.
- R4: On each sub-multiframe end (frameStb and smfStb high together), each spare bit's nibble is formed from its four latest frames, with the oldest frame in bit 3. Bit 8 sets when the Sa6 nibble (built from saBits[2]) differs from the previous nibble.
- R5: Bit 7 sets at a sub-multiframe end when any of the four nibbles differs from the previous one.
- R6: Bit 9 sets at the sub-multiframe end that completes eight consecutive identical Sa6 nibbles.
- R7: When bit 9 is set, bit 14 takes the Sa5 bit of that frame and bits 13..10 take the Sa6 nibble, with the oldest frame in bit 13.
- R8: A pulse on rdStatus or on rdCompanion clears the whole word on the next clock edge. A change or persistence event in the same cycle is still recorded after that clear.
- R9: The first frame after reset sets no bit-change flag, and the first nibble after reset sets no nibble-change flag.
- R10: The run count starts again at 1 whenever the Sa6 nibble changes, and it stops at 8. While the run continues and bit 9 is still set, bit 9 and the captured values are not loaded again. After a clearing read, the next identical nibble sets bit 9 again.
- R11: In a cycle with no frame strobe and no read, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStb | input | 1 | One-cycle strobe: saBits holds a new frame's spare bits |
| smfStb | input | 1 | High with frameStb on the last frame of a sub-multiframe |
| saBits | input | 4 | Spare bits of the frame: [3]=Sa5, [2]=Sa6, [1]=Sa7, [0]=Sa8 |
| rdStatus | input | 1 | Read of this status word (clears it) |
| rdCompanion | input | 1 | Read of the companion interrupt register (clears this word) |
| status | output | 16 | Status word with latched flags and captured values |

## Verification
The assertions assume that smfStb is only high together with frameStb, and that every sub-multiframe holds exactly four frame strobes. The timing checks rely on this, because they link flag rises to a preceding strobe. The stimulus counts frames from reset and raises smfStb only on every fourth frame. Frames are spread out by random idle cycles, and reads land at random, sometimes on the same cycle as a frame. Sa6 patterns are repeated often, so runs reach and pass eight.

// File: rtl/sa_mon_pkg.sv
package sa_mon_pkg;
  localparam int NUM_SA     = 4;
  localparam int SMF_FRAMES = 4;
  localparam int SA5_IDX    = 3;
  localparam int SA6_IDX    = 2;

  typedef struct packed {
    logic frame;    // frame strobe seen
    logic smfEnd;   // last frame of a sub-multiframe
    logic cmpFrame; // previous frame exists, compare bits
    logic cmpNib;   // previous nibble exists, compare nibbles
    logic runHit;   // persistence event, capture values
    logic clear;    // clearing read
  } monStrobes_t;
endpackage

// File: rtl/sa_mon_ctl.sv
module sa_mon_ctl
  import sa_mon_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStb,
  input  logic        smfStb,
  input  logic        rdStatus,
  input  logic        rdCompanion,
  input  logic        sa6Same,
  input  logic        runLatched,
  output monStrobes_t stb
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic          seenFrame, seenNib;
  logic [RW-1:0] runCnt, runNxt;
  logic          smfEnd;

  assign smfEnd = frameStb & smfStb;

  always_comb begin
    if (!seenNib || !sa6Same)          runNxt = RW'(1);
    else if (runCnt < RW'(RUN_LEN))    runNxt = runCnt + RW'(1);
    else                               runNxt = runCnt;
  end

  always_comb begin
    stb.frame    = frameStb;
    stb.smfEnd   = smfEnd;
    stb.cmpFrame = frameStb & seenFrame;
    stb.cmpNib   = smfEnd & seenNib;
    stb.clear    = rdStatus | rdCompanion;
    stb.runHit   = smfEnd && (runNxt == RW'(RUN_LEN)) &&
                   ((runCnt == RW'(RUN_LEN - 1)) || !runLatched);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenFrame <= 1'b0;
      seenNib   <= 1'b0;
      runCnt    <= '0;
    end else begin
      if (frameStb) seenFrame <= 1'b1;
      if (smfEnd) begin
        seenNib <= 1'b1;
        runCnt  <= runNxt;
      end
    end
  end
endmodule

// File: rtl/sa_mon_dp.sv
module sa_mon_dp
  import sa_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SA-1:0] saBits,
  input  monStrobes_t       stb,
  output logic              sa6Same,
  output logic              runLatched,
  output logic [15:0]       status
);
  localparam int SH_W = SMF_FRAMES - 1;

  logic [NUM_SA-1:0]                 prevBits, bitDiff, nibDiff;
  logic [NUM_SA-1:0][SMF_FRAMES-1:0] curNib;

  for (genvar gi = 0; gi < NUM_SA; gi++) begin : laneG
    logic [SH_W-1:0]       shReg;
    logic [SMF_FRAMES-1:0] prevNib;
    assign curNib[gi]  = {shReg, saBits[gi]};
    assign nibDiff[gi] = (curNib[gi] != prevNib);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg   <= '0;
        prevNib <= '0;
      end else begin
        if (stb.frame)  shReg   <= curNib[gi][SH_W-1:0];
        if (stb.smfEnd) prevNib <= curNib[gi];
      end
    end
  end

  assign bitDiff = saBits ^ prevBits;
  assign sa6Same = ~nibDiff[SA6_IDX];

  logic                  sa5V, sa5VNxt;
  logic [SMF_FRAMES-1:0] sa6V, sa6VNxt;
  logic                  run8, sa6N, saN, sa5B, saB;
  logic                  run8Nxt, sa6NNxt, saNNxt, sa5BNxt, saBNxt;

  always_comb begin
    sa5VNxt = stb.clear ? 1'b0 : sa5V;
    sa6VNxt = stb.clear ? '0   : sa6V;
    run8Nxt = stb.clear ? 1'b0 : run8;
    sa6NNxt = stb.clear ? 1'b0 : sa6N;
    saNNxt  = stb.clear ? 1'b0 : saN;
    sa5BNxt = stb.clear ? 1'b0 : sa5B;
    saBNxt  = stb.clear ? 1'b0 : saB;
    if (stb.cmpFrame && |bitDiff)          saBNxt  = 1'b1;
    if (stb.cmpFrame && bitDiff[SA5_IDX])  sa5BNxt = 1'b1;
    if (stb.cmpNib && |nibDiff)            saNNxt  = 1'b1;
    if (stb.cmpNib && nibDiff[SA6_IDX])    sa6NNxt = 1'b1;
    if (stb.runHit) begin
      run8Nxt = 1'b1;
      sa5VNxt = saBits[SA5_IDX];
      sa6VNxt = curNib[SA6_IDX];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBits <= '0;
      sa5V <= 1'b0; sa6V <= '0; run8 <= 1'b0;
      sa6N <= 1'b0; saN  <= 1'b0; sa5B <= 1'b0; saB <= 1'b0;
    end else begin
      if (stb.frame) prevBits <= saBits;
      sa5V <= sa5VNxt; sa6V <= sa6VNxt; run8 <= run8Nxt;
      sa6N <= sa6NNxt; saN  <= saNNxt;  sa5B <= sa5BNxt; saB <= saBNxt;
    end
  end

  assign runLatched = run8;
  assign status = {1'b0, sa5V, sa6V, run8, sa6N, saN, sa5B, saB, 5'b0};
endmodule

// File: rtl/sa_change_monitor.sv
module sa_change_monitor
  import sa_mon_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStb,
  input  logic        smfStb,
  input  logic [3:0]  saBits,
  input  logic        rdStatus,
  input  logic        rdCompanion,
  output logic [15:0] status
);
  monStrobes_t stb;
  logic        sa6Same, runLatched;

  sa_mon_ctl #(.RUN_LEN(RUN_LEN)) u_ctl (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .smfStb(smfStb),
    .rdStatus(rdStatus), .rdCompanion(rdCompanion),
    .sa6Same(sa6Same), .runLatched(runLatched), .stb(stb)
  );

  sa_mon_dp u_dp (
    .clk(clk), .rstN(rstN), .saBits(saBits), .stb(stb),
    .sa6Same(sa6Same), .runLatched(runLatched), .status(status)
  );
endmodule

// File: rtl/sa_change_monitor_chk.sv
module sa_change_monitor_chk (
  input logic        clk,
  input logic        rstN,
  input logic        frameStb,
  input logic        smfStb,
  input logic        rdStatus,
  input logic        rdCompanion,
  input logic [15:0] status
);
  AST_SMF_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    smfStb |-> frameStb); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (status[15] == 1'b0) && (status[4:0] == 5'b0)); // R1
  AST_SA5_WITH_ANY: assert property (@(posedge clk) disable iff (!rstN)
    status[6] |-> status[5]); // R2
  AST_SA6N_WITH_ANY: assert property (@(posedge clk) disable iff (!rstN)
    status[8] |-> status[7]); // R4
  AST_NIB_ON_SMF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[7]) |-> $past(frameStb && smfStb)); // R5
  AST_RUN_ON_SMF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[9]) |-> $past(frameStb && smfStb)); // R6
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStatus || rdCompanion) && !frameStb) |=> (status == 16'h0)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStb && !rdStatus && !rdCompanion) |=> $stable(status)); // R11
endmodule

bind sa_change_monitor sa_change_monitor_chk u_chk (
  .clk(clk), .rstN(rstN), .frameStb(frameStb), .smfStb(smfStb),
  .rdStatus(rdStatus), .rdCompanion(rdCompanion), .status(status)
);

// File: tb/sa_change_monitor_tb.sv
module sa_change_monitor_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0, frameStb = 1'b0, smfStb = 1'b0;
  logic        rdStatus = 1'b0, rdCompanion = 1'b0;
  logic [3:0]  saBits = 4'h0;
  logic [15:0] status;

  sa_change_monitor u_dut (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .smfStb(smfStb),
    .saBits(saBits), .rdStatus(rdStatus), .rdCompanion(rdCompanion),
    .status(status)
  );

  int nCmp = 0, nBad = 0;
  bit done = 1'b0;
  int expSts = 0, prevB = 0, run = 0, fIdx = 0;
  bit haveF = 1'b0, haveN = 1'b0;
  int acc[4], pn[4], pat[4];

  function automatic string tagFor(int b);
    if (b >= 10 && b <= 14) return "R7";
    case (b)
      9: return "R6";
      8: return "R4";
      7: return "R5";
      6: return "R2";
      5: return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic cmpModel();
    int diff;
    nCmp++;
    if (status !== expSts[15:0]) begin
      nBad++;
      diff = int'(status ^ expSts[15:0]);
      for (int b = 15; b >= 0; b--)
        if ((diff >> b) & 1) begin
          $display("FAIL %s: status=%h expected=%h", tagFor(b), status, expSts[15:0]);
          break;
        end
    end
  endtask

  task automatic lit(string tag, logic [15:0] want);
    nCmp++;
    if (status !== want) begin
      nBad++;
      $display("FAIL %s: status=%h expected=%h", tag, status, want);
    end
  endtask

  task automatic modelStep();
    int nx, oldRun;
    bit same6, anyN;
    nx = (rdStatus || rdCompanion) ? 0 : expSts;
    if (frameStb) begin
      if (haveF && int'(saBits) != prevB) begin
        nx |= 1 << 5;
        if (((int'(saBits) ^ prevB) >> 3) & 1) nx |= 1 << 6;
      end
      prevB = int'(saBits);
      haveF = 1'b1;
      for (int i = 0; i < 4; i++) acc[i] = ((acc[i] << 1) | int'(saBits[i])) & 15;
      if (smfStb) begin
        same6 = haveN && (acc[2] == pn[2]);
        anyN = 1'b0;
        for (int i = 0; i < 4; i++) if (acc[i] != pn[i]) anyN = 1'b1;
        if (haveN && anyN) nx |= 1 << 7;
        if (haveN && !same6) nx |= 1 << 8;
        oldRun = run;
        run = same6 ? ((run < 8) ? run + 1 : 8) : 1;
        if (run == 8 && (oldRun == 7 || ((expSts >> 9) & 1) == 0))
          nx = (nx & ~32'h7C00) | (1 << 9) | (int'(saBits[3]) << 14) | (acc[2] << 10);
        for (int i = 0; i < 4; i++) pn[i] = acc[i];
        haveN = 1'b1;
      end
    end
    expSts = nx;
  endtask

  task automatic cyc(bit fs, bit ss, logic [3:0] bits, bit rd, bit rdc);
    @(negedge clk);
    cmpModel();
    frameStb = fs; smfStb = ss; saBits = bits; rdStatus = rd; rdCompanion = rdc;
    modelStep();
  endtask

  task automatic sendFrame(logic [3:0] bits, bit rd, bit rdc);
    cyc(1'b1, (fIdx % 4) == 3, bits, rd, rdc);
    fIdx++;
  endtask

  task automatic settle();
    cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin acc[i] = 0; pn[i] = 0; pat[i] = 0; end
    repeat (3) begin @(negedge clk); cmpModel(); end
    lit("R1", 16'h0000);
    rstN = 1'b1;

    // R9: first frame and first nibble flag nothing
    sendFrame(4'hF, 0, 0); settle(); lit("R9", 16'h0000);
    for (int k = 0; k < 3; k++) begin sendFrame(4'hF, 0, 0); settle(); end
    lit("R9", 16'h0000);
    // R6 R7: seven more identical sub-multiframes complete the run of eight
    for (int k = 0; k < 28; k++) begin sendFrame(4'hF, 0, 0); settle(); end
    lit("R6", 16'h7E00);
    // R10: ninth identical one keeps word as is
    for (int k = 0; k < 4; k++) begin sendFrame(4'hF, 0, 0); settle(); end
    lit("R10", 16'h7E00);
    cyc(0, 0, 4'h0, 1, 0); settle(); lit("R8", 16'h0000);
    for (int k = 0; k < 4; k++) begin sendFrame(4'hF, 0, 0); settle(); end
    lit("R10", 16'h7E00);
    cyc(0, 0, 4'h0, 0, 1); settle(); lit("R8", 16'h0000);
    // R2 R3: Sa5 flips alone
    sendFrame(4'h7, 0, 0); settle(); lit("R2", 16'h0060);
    cyc(0, 0, 4'h0, 1, 0); settle(); lit("R8", 16'h0000);
    // R3: Sa7 flips alone
    sendFrame(4'h5, 0, 0); settle(); lit("R3", 16'h0020);
    cyc(0, 0, 4'h0, 0, 1);
    sendFrame(4'h5, 0, 0); sendFrame(4'h5, 0, 0);

    // random phase, sub-multiframe patterns repeat often
    for (int c = 0; c < 6000; c++) begin
      bit rd, rdc;
      rd  = ($urandom % 16) == 0;
      rdc = ($urandom % 20) == 0;
      if (($urandom % 3) == 0) begin
        if ((fIdx % 4) == 0 && ($urandom % 5) == 0)
          for (int i = 0; i < 4; i++) pat[i] = int'($urandom % 16);
        sendFrame(pat[fIdx % 4][3:0], rd, rdc);
      end else begin
        cyc(0, 0, 4'($urandom), rd, rdc);
      end
    end
    settle();
    @(negedge clk); cmpModel();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule